// File: doc/BRIEF.md
# UART Dual-Counter Bit-Rate Generator

This block produces the bit timing for one asynchronous serial channel. A free-running prescaler offers a set of power-of-two clock taps; a 4-bit select field picks one, and the chosen tap becomes the base enable, a one-cycle pulse that gates all counting. The base enable stays low whenever the channel power enable is off.

Two separate divide counters run from the base enable, one for each direction. Each counter emits a one-cycle bit tick when it reaches the programmed divisor and then reloads to zero. The transmit counter runs freely whenever power and transmit enable are both on. It restarts on the first buffer write and at each frame boundary when another word is already waiting. The receive counter sits at zero until a start bit is reported, then runs for one frame and also marks the middle of each bit with a sample strobe. Shift registers, start-bit detection and framing belong to the neighbouring logic, which supplies the event pulses.

Transmit control states: `TX_OFF` (disabled, counter held), `TX_IDLE` (free running, nothing in flight), `TX_BUSY` (frame in flight, nothing waiting), `TX_PEND` (frame in flight, next word waiting). Transitions: any state to `TX_OFF` when power or transmit enable is 0. `TX_OFF` to `TX_IDLE` once both are 1. `TX_IDLE` to `TX_BUSY` on a write (clear). `TX_BUSY` to `TX_PEND` on a write. `TX_BUSY` to `TX_IDLE` on frame done without a write (no clear). `TX_BUSY` stays in `TX_BUSY` on frame done with a simultaneous write (clear). `TX_PEND` to `TX_BUSY` on frame done (clear). Receive control states: `RX_OFF`, `RX_IDLE` (stopped at zero) and `RX_RUN`. Transitions: any state to `RX_OFF` when power or receive enable is 0. `RX_OFF` to `RX_IDLE` once both are 1. `RX_IDLE` to `RX_RUN` on start. `RX_RUN` to `RX_IDLE` on frame done.

Top module: `uart_bitrate_gen`

## Requirements
- R1: When `power_en_i` is 0 the base enable `base_en_o` is 0, the prescaler is held at zero, and both counters produce no ticks.
- R2: With power on, select value s gives one `base_en_o` pulse every 2^s cycles. A select above N_TAPS-1 uses tap N_TAPS-1.
- R3: A running counter gives a one-cycle tick every (D+1) base-enable pulses, where D is `divisor_i`, or 2 if `divisor_i` is below 2. Two ticks are never on consecutive cycles.
- R4: The transmit counter is held at zero with no tick whenever power or transmit enable is 0. When both are 1 it runs freely.
- R5: A buffer write in `TX_IDLE` clears the transmit counter, so the next tick follows D+1 base enables after the write.
- R6: A frame-done pulse while another word is waiting (`TX_PEND`) clears the transmit counter. A second write while a frame is in flight does not clear it.
- R7: A frame-done pulse with no word waiting (`TX_BUSY`) does not clear the transmit counter, and its tick phase is kept.
- R8: A clear that arrives on the cycle of a terminal count wins: the counter goes to zero, no tick is issued that cycle, and the next tick comes D+1 base enables later.
- R9: The receive counter stays at zero with no tick or strobe until a start pulse. After a start, its first tick comes D+1 base enables later. It is held whenever power or receive enable is 0.
- R10: While running, the receive side gives a mid-bit strobe on the base enable where its count equals D/2 (rounded down), which is (D/2)+1 base enables after the start. The strobe never coincides with a tick.
- R11: A receive frame-done pulse stops the receive counter at zero until the next start. A start pulse during a running frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| power_en_i | input | 1 | Channel power enable |
| tx_en_i | input | 1 | Transmit direction enable |
| rx_en_i | input | 1 | Receive direction enable |
| clk_sel_i | input | SEL_W | Prescaler tap select |
| divisor_i | input | CNT_W | Programmed divisor D |
| tx_wr_i | input | 1 | One-cycle pulse per transmit buffer write |
| tx_frame_done_i | input | 1 | One-cycle pulse when a transmit frame ends |
| rx_start_i | input | 1 | One-cycle pulse when a start bit is detected |
| rx_frame_done_i | input | 1 | One-cycle pulse when a receive frame ends |
| base_en_o | output | 1 | Base clock enable pulse |
| tx_tick_o | output | 1 | Transmit bit-tick strobe |
| rx_tick_o | output | 1 | Receive bit-tick strobe |
| rx_mid_o | output | 1 | Receive mid-bit sample strobe |

## Verification
The bench builds the block with N_TAPS = 4, so a select value of 7 reaches the clamp to the top tap. With the default CNT_W of 8 it programs small divisors (0, 1, 5 and 9) with tap 0, where every cycle is a base enable. This puts the divisor floor, exact tick spacing, clear-versus-terminal-count collisions and the mid-bit point within a dozen cycles, so each event can be placed on a chosen edge of the count.

// File: rtl/brg_pkg.sv
package brg_pkg;

    // Transmit direction control
    typedef enum logic [1:0] {
        TX_OFF  = 2'd0,
        TX_IDLE = 2'd1,
        TX_BUSY = 2'd2,
        TX_PEND = 2'd3
    } tx_state_t;

    // Receive direction control
    typedef enum logic [1:0] {
        RX_OFF  = 2'd0,
        RX_IDLE = 2'd1,
        RX_RUN  = 2'd2
    } rx_state_t;

endpackage

// File: rtl/brg_prescaler.sv
// Free-running power-of-two prescaler with a tap selector.
// Tap k fires once every 2^k cycles; output is forced low without power.
module brg_prescaler #(
    parameter int N_TAPS = 16,
    parameter int SEL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             power_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             base_en_o
);

    localparam int PRE_W = (N_TAPS > 1) ? N_TAPS - 1 : 1;
    localparam logic [SEL_W-1:0] SEL_TOP = SEL_W'(N_TAPS - 1);

    logic [PRE_W-1:0]  pre_cnt;
    logic [N_TAPS-1:0] tap_hit;
    logic [SEL_W-1:0]  sel_eff;
    logic              hit_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (!power_i) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    assign tap_hit[0] = 1'b1;

    genvar k;
    generate
        for (k = 1; k < N_TAPS; k++) begin : g_tap
            assign tap_hit[k] = &pre_cnt[k-1:0];
        end
    endgenerate

    assign sel_eff = (sel_i > SEL_TOP) ? SEL_TOP : sel_i;

    always_comb begin
        hit_sel = 1'b0;
        for (int t = 0; t < N_TAPS; t++) begin
            if (sel_eff == SEL_W'(t)) begin
                hit_sel = tap_hit[t];
            end
        end
    end

    assign base_en_o = power_i & hit_sel;

endmodule

// File: rtl/brg_divcnt.sv
// Programmable divide counter: ticks and reloads on reaching the divisor.
// A clear or a stop has priority over the terminal count.
module brg_divcnt #(
    parameter int CNT_W   = 8,
    parameter bit HAS_MID = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] div_i,
    output logic             tick_o,
    output logic             mid_o
);

    localparam logic [CNT_W-1:0] DIV_FLOOR = CNT_W'(2);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] div_eff;
    logic [CNT_W-1:0] half_pt;
    logic             hold;
    logic             at_end;

    assign div_eff = (div_i < DIV_FLOOR) ? DIV_FLOOR : div_i;
    assign half_pt = div_eff >> 1;
    assign hold    = !run_i || clr_i;
    // >= keeps the counter bounded when the divisor is lowered on the fly
    assign at_end  = (cnt >= div_eff);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= 1'b0;
            if (hold) begin
                cnt <= '0;
            end else if (step_i) begin
                if (at_end) begin
                    cnt    <= '0;
                    tick_o <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    generate
        if (HAS_MID) begin : g_mid
            logic mid_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mid_q <= 1'b0;
                end else begin
                    mid_q <= !hold && step_i && !at_end && (cnt == half_pt);
                end
            end
            assign mid_o = mid_q;
        end else begin : g_nomid
            assign mid_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/brg_tx_ctrl.sv
// Transmit restart control: decides when the transmit counter runs and clears.
module brg_tx_ctrl
    import brg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic power_i,
    input  logic en_i,
    input  logic wr_i,
    input  logic done_i,
    output logic run_o,
    output logic clr_o
);

    tx_state_t state, state_nx;
    logic      live;

    assign live = power_i && en_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (!live) begin
            state_nx = TX_OFF;
        end else begin
            unique case (state)
                TX_OFF:  state_nx = TX_IDLE;
                TX_IDLE: if (wr_i) state_nx = TX_BUSY;
                TX_BUSY: begin
                    if (done_i) begin
                        state_nx = wr_i ? TX_BUSY : TX_IDLE;
                    end else if (wr_i) begin
                        state_nx = TX_PEND;
                    end
                end
                TX_PEND: if (done_i) state_nx = TX_BUSY;
                default: state_nx = TX_OFF;
            endcase
        end
    end

    always_comb begin
        run_o = 1'b0;
        clr_o = 1'b0;
        if (live) begin
            unique case (state)
                TX_OFF:  run_o = 1'b0;
                TX_IDLE: begin
                    run_o = 1'b1;
                    clr_o = wr_i;
                end
                TX_BUSY: begin
                    run_o = 1'b1;
                    clr_o = done_i && wr_i;
                end
                TX_PEND: begin
                    run_o = 1'b1;
                    clr_o = done_i;
                end
                default: run_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/brg_rx_ctrl.sv
// Receive run control: counter runs only between a start and its frame end.
module brg_rx_ctrl
    import brg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic power_i,
    input  logic en_i,
    input  logic start_i,
    input  logic done_i,
    output logic run_o,
    output logic clr_o
);

    rx_state_t state, state_nx;
    logic      live;

    assign live = power_i && en_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (!live) begin
            state_nx = RX_OFF;
        end else begin
            unique case (state)
                RX_OFF:  state_nx = RX_IDLE;
                RX_IDLE: if (start_i) state_nx = RX_RUN;
                RX_RUN:  if (done_i)  state_nx = RX_IDLE;
                default: state_nx = RX_OFF;
            endcase
        end
    end

    always_comb begin
        run_o = 1'b0;
        clr_o = 1'b0;
        if (live) begin
            unique case (state)
                RX_OFF:  run_o = 1'b0;
                RX_IDLE: clr_o = start_i;
                RX_RUN:  run_o = !done_i;
                default: run_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/uart_bitrate_gen.sv
// Bit-rate generator for one asynchronous serial channel.
module uart_bitrate_gen #(
    parameter int CNT_W  = 8,
    parameter int SEL_W  = 4,
    parameter int N_TAPS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             power_en_i,
    input  logic             tx_en_i,
    input  logic             rx_en_i,
    input  logic [SEL_W-1:0] clk_sel_i,
    input  logic [CNT_W-1:0] divisor_i,
    input  logic             tx_wr_i,
    input  logic             tx_frame_done_i,
    input  logic             rx_start_i,
    input  logic             rx_frame_done_i,
    output logic             base_en_o,
    output logic             tx_tick_o,
    output logic             rx_tick_o,
    output logic             rx_mid_o
);

    logic tx_run, tx_clr;
    logic rx_run, rx_clr;
    logic tx_mid_unused;

    brg_prescaler #(
        .N_TAPS (N_TAPS),
        .SEL_W  (SEL_W)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .power_i   (power_en_i),
        .sel_i     (clk_sel_i),
        .base_en_o (base_en_o)
    );

    brg_tx_ctrl u_txc (
        .clk     (clk),
        .rst_n   (rst_n),
        .power_i (power_en_i),
        .en_i    (tx_en_i),
        .wr_i    (tx_wr_i),
        .done_i  (tx_frame_done_i),
        .run_o   (tx_run),
        .clr_o   (tx_clr)
    );

    brg_rx_ctrl u_rxc (
        .clk     (clk),
        .rst_n   (rst_n),
        .power_i (power_en_i),
        .en_i    (rx_en_i),
        .start_i (rx_start_i),
        .done_i  (rx_frame_done_i),
        .run_o   (rx_run),
        .clr_o   (rx_clr)
    );

    brg_divcnt #(
        .CNT_W   (CNT_W),
        .HAS_MID (1'b0)
    ) u_txcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (tx_run),
        .clr_i  (tx_clr),
        .step_i (base_en_o),
        .div_i  (divisor_i),
        .tick_o (tx_tick_o),
        .mid_o  (tx_mid_unused)
    );

    brg_divcnt #(
        .CNT_W   (CNT_W),
        .HAS_MID (1'b1)
    ) u_rxcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (rx_run),
        .clr_i  (rx_clr),
        .step_i (base_en_o),
        .div_i  (divisor_i),
        .tick_o (rx_tick_o),
        .mid_o  (rx_mid_o)
    );

endmodule

// File: rtl/brg_checker.sv
module brg_checker (
    input logic clk,
    input logic rst_n,
    input logic power_en_i,
    input logic tx_en_i,
    input logic rx_en_i,
    input logic base_en_o,
    input logic tx_tick_o,
    input logic rx_tick_o,
    input logic rx_mid_o
);

    // R1
    base_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !power_en_i |-> !base_en_o);

    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(power_en_i && tx_en_i) |=> !tx_tick_o);

    // R3
    tx_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick_o |=> !tx_tick_o);

    // R3
    rx_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tick_o |=> !rx_tick_o);

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(power_en_i && rx_en_i) |=> !(rx_tick_o || rx_mid_o));

    // R10
    mid_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_tick_o && rx_mid_o));

endmodule

bind uart_bitrate_gen brg_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .power_en_i (power_en_i),
    .tx_en_i    (tx_en_i),
    .rx_en_i    (rx_en_i),
    .base_en_o  (base_en_o),
    .tx_tick_o  (tx_tick_o),
    .rx_tick_o  (rx_tick_o),
    .rx_mid_o   (rx_mid_o)
);

// File: tb/uart_bitrate_gen_tb_top.sv
`timescale 1ns/1ps
module uart_bitrate_gen_tb_top;

    localparam int CNT_W  = 8;
    localparam int SEL_W  = 4;
    localparam int N_TAPS = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             power_en, tx_en, rx_en;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] div;
    logic             tx_wr, tx_done, rx_start, rx_done;
    logic             base_en, tx_tick, rx_tick, rx_mid;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    uart_bitrate_gen #(
        .CNT_W  (CNT_W),
        .SEL_W  (SEL_W),
        .N_TAPS (N_TAPS)
    ) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .power_en_i      (power_en),
        .tx_en_i         (tx_en),
        .rx_en_i         (rx_en),
        .clk_sel_i       (sel),
        .divisor_i       (div),
        .tx_wr_i         (tx_wr),
        .tx_frame_done_i (tx_done),
        .rx_start_i      (rx_start),
        .rx_frame_done_i (rx_done),
        .base_en_o       (base_en),
        .tx_tick_o       (tx_tick),
        .rx_tick_o       (rx_tick),
        .rx_mid_o        (rx_mid)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic sig(input int which);
        case (which)
            0: sig = base_en;
            1: sig = tx_tick;
            2: sig = rx_tick;
            default: sig = rx_mid;
        endcase
    endfunction

    // which: 0 write, 1 tx done, 2 rx start, 3 rx done; event edge is the next posedge
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: tx_wr = 1'b1;
            1: tx_done = 1'b1;
            2: rx_start = 1'b1;
            default: rx_done = 1'b1;
        endcase
        @(posedge clk);
        #1;
        tx_wr = 1'b0; tx_done = 1'b0; rx_start = 1'b0; rx_done = 1'b0;
    endtask

    // edges until the signal is seen, -1 if not within max
    task automatic wait_ev(input int which, input int max, output int n);
        n = -1;
        for (int i = 1; i <= max; i++) begin
            @(posedge clk);
            #1;
            if (sig(which)) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic count_ev(input int which, input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            #1;
            if (sig(which)) n++;
        end
    endtask

    task automatic restart_tx();
        @(negedge clk);
        tx_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        tx_en = 1'b1;
    endtask

    task automatic t_reset();
        check("R1", "base_en after reset", int'(base_en), 0);
        check("R1", "tx_tick after reset", int'(tx_tick), 0);
        check("R9", "rx_tick after reset", int'(rx_tick), 0);
        check("R10", "rx_mid after reset", int'(rx_mid), 0);
    endtask

    task automatic t_power_off();
        int n;
        @(negedge clk);
        tx_en = 1'b1; rx_en = 1'b1;
        pulse(0);
        pulse(2);
        count_ev(0, 40, n);
        check("R1", "base_en pulses unpowered", n, 0);
        count_ev(1, 40, n);
        check("R1", "tx ticks unpowered", n, 0);
    endtask

    task automatic t_taps();
        int n;
        @(negedge clk);
        power_en = 1'b1; sel = 4'd0;
        count_ev(0, 20, n);
        check("R2", "tap 0 pulses in 20", n, 20);
        @(negedge clk);
        sel = 4'd2;
        count_ev(0, 64, n);
        check("R2", "tap 2 pulses in 64", n, 16);
        @(negedge clk);
        sel = 4'd7;
        count_ev(0, 64, n);
        check("R2", "clamped select pulses in 64", n, 8);
        @(negedge clk);
        sel = 4'd0;
    endtask

    task automatic t_free_run();
        int n;
        restart_tx();
        wait_ev(1, 20, n);
        wait_ev(1, 20, n);
        check("R4", "free-run tick spacing D=5", n, 6);
        wait_ev(1, 20, n);
        check("R3", "repeat tick spacing D=5", n, 6);
    endtask

    task automatic t_div_floor();
        int n;
        @(negedge clk);
        div = 8'd0;
        wait_ev(1, 20, n);
        wait_ev(1, 20, n);
        check("R3", "spacing with divisor 0", n, 3);
        @(negedge clk);
        div = 8'd1;
        wait_ev(1, 20, n);
        wait_ev(1, 20, n);
        check("R3", "spacing with divisor 1", n, 3);
        @(negedge clk);
        div = 8'd9;
        wait_ev(1, 30, n);
        wait_ev(1, 30, n);
        check("R3", "spacing with divisor 9", n, 10);
        @(negedge clk);
        div = 8'd5;
    endtask

    task automatic t_tx_disable();
        int n;
        @(negedge clk);
        tx_en = 1'b0;
        count_ev(1, 30, n);
        check("R4", "tx ticks with tx enable low", n, 0);
    endtask

    task automatic t_first_write();
        int n;
        restart_tx();
        repeat (4) @(posedge clk);
        pulse(0);
        wait_ev(1, 20, n);
        check("R5", "first tick after write", n, 6);
    endtask

    task automatic t_done_no_pending();
        int n;
        restart_tx();
        pulse(0);
        repeat (2) @(posedge clk);
        pulse(1);
        wait_ev(1, 20, n);
        check("R7", "tick after done with nothing waiting", n, 3);
    endtask

    task automatic t_done_pending();
        int n;
        restart_tx();
        pulse(0);
        pulse(0);
        pulse(1);
        wait_ev(1, 20, n);
        check("R6", "tick after done with word waiting", n, 6);
    endtask

    task automatic t_clear_priority();
        int n;
        restart_tx();
        wait_ev(1, 20, n);
        repeat (5) @(posedge clk);
        #1;
        pulse(0);
        check("R8", "tick suppressed on collision", int'(tx_tick), 0);
        wait_ev(1, 20, n);
        check("R8", "tick after collision clear", n, 6);
    endtask

    task automatic t_rx_frame();
        int n, mid_n, tick_n;
        count_ev(2, 40, n);
        check("R9", "rx ticks before start", n, 0);
        count_ev(3, 40, n);
        check("R10", "mid strobes before start", n, 0);
        pulse(2);
        mid_n = -1; tick_n = -1;
        for (int i = 1; i <= 12; i++) begin
            @(posedge clk);
            #1;
            if (rx_mid && mid_n < 0) mid_n = i;
            if (rx_tick && tick_n < 0) tick_n = i;
        end
        check("R10", "mid strobe after start", mid_n, 3);
        check("R9", "first rx tick after start", tick_n, 6);
    endtask

    task automatic t_rx_stop();
        int n;
        pulse(3);
        count_ev(2, 40, n);
        check("R11", "rx ticks after frame done", n, 0);
        pulse(2);
        repeat (2) @(posedge clk);
        pulse(2);
        wait_ev(2, 20, n);
        check("R11", "restart ignored during frame", n, 3);
    endtask

    initial begin
        rst_n = 1'b0;
        power_en = 1'b0; tx_en = 1'b0; rx_en = 1'b0;
        sel = '0; div = 8'd5;
        tx_wr = 1'b0; tx_done = 1'b0; rx_start = 1'b0; rx_done = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_power_off();
        t_taps();
        t_free_run();
        t_div_floor();
        t_tx_disable();
        t_first_write();
        t_done_no_pending();
        t_done_pending();
        t_clear_priority();
        t_rx_frame();
        t_rx_stop();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule